// File: doc/BRIEF.md
# Graphics DRAM Write Burst Sequencer

This block sits on the controller side of a graphics DDR SDRAM channel. It accepts one write request at a time through a valid/ready handshake and turns it into a WRITE command on the command pins, followed by a four-element data burst and its write strobe. Each request carries a bank, a column address, an auto-precharge flag and four data elements. Data and strobe are modelled as two half-cycle slots per core clock: slot 0 is the first half of the cycle and slot 1 is the second half.

The write latency and the write recovery time are run-time inputs. The block places the burst the programmed number of clocks after the command and frames it with a strobe preamble and postamble. It refuses any request that would cut short or reorder an earlier burst. For each bank it reports when a precharge may be issued, or that the bank is being closed by auto precharge.

Top module: `gddr_wr_seq`

## Requirements
- R1: In the cycle after a request is accepted, the command pins carry WRITE (cs_n=0, ras_n=1, cas_n=0, we_n=0). In every other cycle after reset they carry NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1). cke is always 1.
- R2: With a WRITE, addr[7:0] carries col[7:0], addr[9] carries col[8], addr[8] carries the auto-precharge flag (1 enables it), addr[11:10] is 0, and ba carries the bank. With a NOP, addr and ba are 0.
- R3: For a WRITE on the pins in cycle C with latency WL, dq_oe is high in cycles C+WL and C+WL+1 only. The data slots carry, as {dq_slot1, dq_slot0}, the elements {e1, e0} and then {e3, e2}, where element k is req_data[8k+7:8k]. When dq_oe is low, both slots are 0.
- R4: In every cycle that carries data, dqs_oe = 2'b11 and dqs_lvl = 2'b01 (bit 0 is slot 0, bit 1 is slot 1). Slot 0 is high and slot 1 is low, so the first element meets a rising strobe edge.
- R5: In a cycle without data, dqs_lvl is 0. dqs_oe[1] (the preamble) is 1 only when the next cycle carries data. dqs_oe[0] (the postamble) is 1 only when the previous cycle carried data.
- R6: req_ready is 1 only when all of the following hold: cfg_wl is between 1 and 7, no WRITE is on the pins in this cycle, and no data is scheduled in cycle now+1+cfg_wl or later. A request is accepted when req_valid and req_ready are both 1.
- R7: Writes with the same latency accepted every second cycle produce gapless data, with no preamble or postamble between the bursts.
- R8: pre_ok[b] is 1 after reset. It is 0 from the cycle after a write to bank b is accepted. It becomes 1 again in cycle L+1+T, where L is the last data cycle of the bank's newest write and T is cfg_twr as sampled in cycle L.
- R9: After a write with auto precharge, pre_ok[b] stays 0. closing[b] is 1 from the cycle after acceptance through cycle L+T, and is 0 afterwards. Both stay 0 until a later write without auto precharge to that bank recovers.
- R10: req_data, req_bank, req_col and req_ap have no effect on any output unless a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Request may be accepted in this cycle |
| req_bank | input | 3 | Target bank |
| req_col | input | 9 | Starting column |
| req_ap | input | 1 | Auto precharge after the burst |
| req_data | input | 32 | Four data elements, element 0 in the low byte |
| cfg_wl | input | 3 | Write latency in clocks (1 to 7) |
| cfg_twr | input | 4 | Write recovery time in clocks |
| cke | output | 1 | Clock enable, held high |
| cs_n | output | 1 | Chip select |
| ras_n | output | 1 | Row strobe |
| cas_n | output | 1 | Column strobe |
| we_n | output | 1 | Write enable |
| addr | output | 12 | Address lines |
| ba | output | 3 | Bank lines |
| dq_oe | output | 1 | Data output enable |
| dq_slot0 | output | 8 | Data, first half cycle |
| dq_slot1 | output | 8 | Data, second half cycle |
| dqs_oe | output | 2 | Strobe enable per half cycle |
| dqs_lvl | output | 2 | Strobe level per half cycle |
| pre_ok | output | 8 | Precharge allowed, per bank |
| closing | output | 8 | Bank closing by auto precharge |

## Verification
The bench targets the following corner cases:

- A latency drop from 6 to 2 while a burst is pending. A block that checked only the new burst's own slots would let the new data overtake the old burst.
- Bursts separated by exactly one idle cycle. Here a postamble and a preamble share a cycle, and wrong strobe framing would leave a half-cycle undriven or high.
- Latency 1, where the preamble falls in the command cycle itself.
- A write recovery of 0 and the largest write recovery value. An off-by-one in the recovery count moves the rise of pre_ok by a cycle.
- Auto-precharge writes. Here pre_ok must never rise, and closing must drop exactly when recovery ends.

// File: rtl/gws_pkg.sv
`timescale 1ns/1ps
package gws_pkg;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    localparam cmd_pins_t PINS_NOP   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam cmd_pins_t PINS_WRITE = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b0};

endpackage

// File: rtl/gws_cmd_enc.sv
`timescale 1ns/1ps
module gws_cmd_enc
    import gws_pkg::*;
#(
    parameter int BAW    = 3,
    parameter int COLW   = 9,
    parameter int ADDRW  = 12,
    parameter int AP_BIT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [BAW-1:0]   bank,
    input  logic [COLW-1:0]  col,
    input  logic             ap,
    output cmd_pins_t        pins,
    output logic [ADDRW-1:0] addr,
    output logic [BAW-1:0]   ba,
    output logic             is_write
);

    typedef struct packed {
        cmd_pins_t        pins;
        logic [ADDRW-1:0] addr;
        logic [BAW-1:0]   ba;
    } enc_t;

    enc_t enc_d, enc_q;

    always_comb begin
        enc_d      = '0;
        enc_d.pins = PINS_NOP;
        if (accept) begin
            enc_d.pins = PINS_WRITE;
            enc_d.ba   = bank;
            enc_d.addr[AP_BIT] = ap;
            // column bits skip over the auto-precharge position
            for (int i = 0; i < COLW; i++) begin
                if (i < AP_BIT) enc_d.addr[i]     = col[i];
                else            enc_d.addr[i + 1] = col[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enc_q      <= '0;
            enc_q.pins <= PINS_NOP;
        end else begin
            enc_q <= enc_d;
        end
    end

    assign pins     = enc_q.pins;
    assign addr     = enc_q.addr;
    assign ba       = enc_q.ba;
    assign is_write = (enc_q.pins == PINS_WRITE);

endmodule

// File: rtl/gws_sched.sv
`timescale 1ns/1ps
module gws_sched #(
    parameter int DW    = 8,
    parameter int BAW   = 3,
    parameter int WLMAX = 7,
    parameter int WLW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept,
    input  logic [WLW-1:0]  wl,
    input  logic [BAW-1:0]  bank,
    input  logic [4*DW-1:0] data,
    output logic            room,
    output logic            dq_oe,
    output logic [DW-1:0]   dq_slot0,
    output logic [DW-1:0]   dq_slot1,
    output logic [1:0]      dqs_oe,
    output logic [1:0]      dqs_lvl,
    output logic            burst_end,
    output logic [BAW-1:0]  end_bank
);

    // slot k describes the cycle k clocks from now
    localparam int DEPTH = WLMAX + 2;

    typedef struct packed {
        logic           valid;
        logic           last;
        logic [BAW-1:0] bank;
        logic [DW-1:0]  hi;
        logic [DW-1:0]  lo;
    } beat_t;

    typedef struct packed {
        beat_t [DEPTH-1:0] slots;
        logic              prev_dv;
    } sched_t;

    sched_t st_d, st_q;
    beat_t  beat_first, beat_second;

    always_comb begin
        beat_first  = '{valid: 1'b1, last: 1'b0, bank: bank,
                        hi: data[2*DW-1:DW], lo: data[DW-1:0]};
        beat_second = '{valid: 1'b1, last: 1'b1, bank: bank,
                        hi: data[4*DW-1:3*DW], lo: data[3*DW-1:2*DW]};
    end

    always_comb begin
        room = 1'b1;
        for (int j = 0; j < DEPTH; j++) begin
            if (j > int'(wl) && st_q.slots[j].valid) room = 1'b0;
        end
    end

    always_comb begin
        st_d         = '0;
        st_d.prev_dv = st_q.slots[0].valid;
        for (int k = 0; k < DEPTH - 1; k++) begin
            st_d.slots[k] = st_q.slots[k + 1];
        end
        if (accept) begin
            for (int k = 0; k < DEPTH; k++) begin
                if (k == int'(wl))     st_d.slots[k] = beat_first;
                if (k == int'(wl) + 1) st_d.slots[k] = beat_second;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dq_oe     = st_q.slots[0].valid;
    assign dq_slot0  = st_q.slots[0].valid ? st_q.slots[0].lo : '0;
    assign dq_slot1  = st_q.slots[0].valid ? st_q.slots[0].hi : '0;
    assign dqs_oe[0] = st_q.slots[0].valid | st_q.prev_dv;
    assign dqs_oe[1] = st_q.slots[0].valid | st_q.slots[1].valid;
    assign dqs_lvl   = st_q.slots[0].valid ? 2'b01 : 2'b00;
    assign burst_end = st_q.slots[0].valid & st_q.slots[0].last;
    assign end_bank  = st_q.slots[0].bank;

endmodule

// File: rtl/gws_bank_track.sv
`timescale 1ns/1ps
module gws_bank_track #(
    parameter int NBANK = 8,
    parameter int BAW   = 3,
    parameter int TWRW  = 4,
    parameter int WLMAX = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [BAW-1:0]   acc_bank,
    input  logic             acc_ap,
    input  logic             burst_end,
    input  logic [BAW-1:0]   end_bank,
    input  logic [TWRW-1:0]  twr,
    output logic [NBANK-1:0] pre_ok,
    output logic [NBANK-1:0] closing
);

    localparam int CNTW = $clog2(WLMAX + 4);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        typedef struct packed {
            logic [CNTW-1:0] inflight;
            logic [TWRW-1:0] rec;
            logic            ap;
        } bank_t;

        bank_t bk_d, bk_q;
        logic  hit_acc, hit_end;

        assign hit_acc = accept && (acc_bank == BAW'(b));
        assign hit_end = burst_end && (end_bank == BAW'(b));

        always_comb begin
            bk_d          = bk_q;
            bk_d.inflight = bk_q.inflight + CNTW'(hit_acc) - CNTW'(hit_end);
            if (hit_end)            bk_d.rec = twr;
            else if (bk_q.rec != 0) bk_d.rec = bk_q.rec - 1'b1;
            if (hit_acc)            bk_d.ap  = acc_ap;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bk_q <= '0;
            else        bk_q <= bk_d;
        end

        assign pre_ok[b]  = !bk_q.ap && (bk_q.inflight == 0) && (bk_q.rec == 0);
        assign closing[b] =  bk_q.ap && ((bk_q.inflight != 0) || (bk_q.rec != 0));
    end

endmodule

// File: rtl/gddr_wr_seq.sv
`timescale 1ns/1ps
module gddr_wr_seq
    import gws_pkg::*;
#(
    parameter int DW    = 8,
    parameter int NBANK = 8,
    parameter int COLW  = 9,
    parameter int ADDRW = 12,
    parameter int WLMAX = 7,
    parameter int TWRW  = 4,
    localparam int BAW  = $clog2(NBANK),
    localparam int WLW  = $clog2(WLMAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [BAW-1:0]   req_bank,
    input  logic [COLW-1:0]  req_col,
    input  logic             req_ap,
    input  logic [4*DW-1:0]  req_data,
    input  logic [WLW-1:0]   cfg_wl,
    input  logic [TWRW-1:0]  cfg_twr,
    output logic             cke,
    output logic             cs_n,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic [ADDRW-1:0] addr,
    output logic [BAW-1:0]   ba,
    output logic             dq_oe,
    output logic [DW-1:0]    dq_slot0,
    output logic [DW-1:0]    dq_slot1,
    output logic [1:0]       dqs_oe,
    output logic [1:0]       dqs_lvl,
    output logic [NBANK-1:0] pre_ok,
    output logic [NBANK-1:0] closing
);

    logic           accept, room, cmd_busy, wl_ok;
    logic           burst_end;
    logic [BAW-1:0] end_bank;
    cmd_pins_t      pins;

    assign wl_ok     = (cfg_wl != '0) && (int'(cfg_wl) <= WLMAX);
    assign req_ready = wl_ok && room && !cmd_busy;
    assign accept    = req_valid && req_ready;
    assign cke       = 1'b1;

    gws_cmd_enc #(.BAW(BAW), .COLW(COLW), .ADDRW(ADDRW), .AP_BIT(8)) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .bank     (req_bank),
        .col      (req_col),
        .ap       (req_ap),
        .pins     (pins),
        .addr     (addr),
        .ba       (ba),
        .is_write (cmd_busy)
    );

    assign cs_n  = pins.cs_n;
    assign ras_n = pins.ras_n;
    assign cas_n = pins.cas_n;
    assign we_n  = pins.we_n;

    gws_sched #(.DW(DW), .BAW(BAW), .WLMAX(WLMAX), .WLW(WLW)) u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .wl        (cfg_wl),
        .bank      (req_bank),
        .data      (req_data),
        .room      (room),
        .dq_oe     (dq_oe),
        .dq_slot0  (dq_slot0),
        .dq_slot1  (dq_slot1),
        .dqs_oe    (dqs_oe),
        .dqs_lvl   (dqs_lvl),
        .burst_end (burst_end),
        .end_bank  (end_bank)
    );

    gws_bank_track #(.NBANK(NBANK), .BAW(BAW), .TWRW(TWRW), .WLMAX(WLMAX)) u_banks (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .acc_bank  (req_bank),
        .acc_ap    (req_ap),
        .burst_end (burst_end),
        .end_bank  (end_bank),
        .twr       (cfg_twr),
        .pre_ok    (pre_ok),
        .closing   (closing)
    );

endmodule

// File: rtl/gddr_wr_seq_chk.sv
`timescale 1ns/1ps
module gddr_wr_seq_chk #(
    parameter int NBANK = 8,
    parameter int WLW   = 3,
    localparam int BAW  = $clog2(NBANK)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [BAW-1:0]   req_bank,
    input logic             req_ap,
    input logic [WLW-1:0]   cfg_wl,
    input logic             cs_n,
    input logic             cas_n,
    input logic             we_n,
    input logic             dq_oe,
    input logic [1:0]       dqs_oe,
    input logic [1:0]       dqs_lvl,
    input logic [NBANK-1:0] pre_ok,
    input logic [NBANK-1:0] closing
);

    logic wr_on_pins;
    assign wr_on_pins = !cs_n && !cas_n && !we_n;

    assert_write_follows_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_on_pins |-> $past(req_valid && req_ready));

    assert_cmd_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_on_pins |=> !wr_on_pins);

    assert_ready_wl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wl == '0) |-> !req_ready);

    assert_burst_two_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |=> dq_oe);

    assert_data_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (dqs_oe == 2'b11 && dqs_lvl == 2'b01));

    assert_strobe_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> (dqs_lvl == 2'b00));

    assert_accept_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !pre_ok[$past(req_bank)]);

    assert_ap_closing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_ap) |=> closing[$past(req_bank)]);

    assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_ok & closing) == '0);

endmodule

bind gddr_wr_seq gddr_wr_seq_chk #(.NBANK(NBANK), .WLW(WLW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_bank  (req_bank),
    .req_ap    (req_ap),
    .cfg_wl    (cfg_wl),
    .cs_n      (cs_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .dq_oe     (dq_oe),
    .dqs_oe    (dqs_oe),
    .dqs_lvl   (dqs_lvl),
    .pre_ok    (pre_ok),
    .closing   (closing)
);

// File: tb/gddr_wr_seq_bench.sv
`timescale 1ns/1ps
module gddr_wr_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_bank = '0;
    logic [8:0]  req_col = '0;
    logic        req_ap = 1'b0;
    logic [31:0] req_data = '0;
    logic [2:0]  cfg_wl = 3'd1;
    logic [3:0]  cfg_twr = '0;
    logic        cke, cs_n, ras_n, cas_n, we_n, dq_oe;
    logic [11:0] addr;
    logic [2:0]  ba;
    logic [7:0]  dq_slot0, dq_slot1;
    logic [1:0]  dqs_oe, dqs_lvl;
    logic [7:0]  pre_ok, closing;

    always #10 clk = ~clk;

    gddr_wr_seq u_gddr_wr_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(req_bank), .req_col(req_col), .req_ap(req_ap), .req_data(req_data),
        .cfg_wl(cfg_wl), .cfg_twr(cfg_twr), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba), .dq_oe(dq_oe),
        .dq_slot0(dq_slot0), .dq_slot1(dq_slot1), .dqs_oe(dqs_oe), .dqs_lvl(dqs_lvl),
        .pre_ok(pre_ok), .closing(closing)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;

    // reference model state
    logic [15:0] exp_data[int];
    int          end_bank_at[int];
    int          last_data = -100;
    int          cmd_cyc = -100;
    logic [11:0] cmd_addr;
    logic [2:0]  cmd_ba;
    int          pend[8];
    int          rdy_at[8];
    bit          apb[8];

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    task automatic tick(input bit v, input int bank, input int col, input bit ap,
                        input logic [31:0] dat, input int wl, input int twr);
        bit dv, pre, post, rdy;
        logic [7:0] e_ok, e_cl;
        @(negedge clk);
        dv   = exp_data.exists(cyc);
        pre  = exp_data.exists(cyc + 1);
        post = exp_data.exists(cyc - 1);
        chk("R1 cke", cke, 1'b1);
        if (cmd_cyc == cyc) begin
            chk("R1 write pins", {cs_n, ras_n, cas_n, we_n}, 4'b0100);
            chk("R2 write addr", addr, cmd_addr);
            chk("R2 write bank", ba, cmd_ba);
        end else begin
            chk("R1 nop pins", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
            chk("R2 nop addr/ba", {addr, ba}, 15'd0);
        end
        chk("R3 dq_oe", dq_oe, dv);
        chk("R3 R10 dq slots", {dq_slot1, dq_slot0}, dv ? exp_data[cyc] : 16'd0);
        if (dv) chk("R4 R7 strobe in data", {dqs_oe, dqs_lvl}, 4'b1101);
        else    chk("R5 pre/postamble", {dqs_oe, dqs_lvl}, {pre, post, 2'b00});
        for (int b = 0; b < 8; b++) begin
            e_ok[b] = !apb[b] && pend[b] == 0 && cyc >= rdy_at[b];
            e_cl[b] =  apb[b] && (pend[b] != 0 || cyc < rdy_at[b]);
        end
        chk("R8 pre_ok", pre_ok, e_ok);
        chk("R9 closing", closing, e_cl);
        req_valid = v; req_bank = 3'(bank); req_col = 9'(col); req_ap = ap;
        req_data = dat; cfg_wl = 3'(wl); cfg_twr = 4'(twr);
        #1;
        if (end_bank_at.exists(cyc)) begin
            pend[end_bank_at[cyc]]--;
            rdy_at[end_bank_at[cyc]] = cyc + 1 + twr;
        end
        rdy = (wl >= 1) && (wl <= 7) && (cmd_cyc != cyc) && (last_data < cyc + 1 + wl);
        chk("R6 req_ready", req_ready, rdy);
        if (v && rdy) begin
            cmd_cyc  = cyc + 1;
            cmd_addr = {2'b00, 1'(col >> 8), ap, 8'(col)};
            cmd_ba   = 3'(bank);
            exp_data[cyc + 1 + wl] = dat[15:0];
            exp_data[cyc + 2 + wl] = dat[31:16];
            end_bank_at[cyc + 2 + wl] = bank;
            last_data = cyc + 2 + wl;
            pend[bank]++;
            apb[bank] = ap;
        end
        @(posedge clk);
        cyc++;
    endtask

    task automatic idle(input int n, input int wl, input int twr);
        for (int i = 0; i < n; i++) tick(0, 7, 511, 1, 32'hDEADBEEF, wl, twr);
    endtask

    initial begin
        for (int b = 0; b < 8; b++) begin pend[b] = 0; rdy_at[b] = -1000; apb[b] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // reset state, garbage inputs ignored (R10)
        idle(3, 3, 2);
        // single write, WL=3, tWR=2 (R1 R2 R3 R8)
        tick(1, 2, 9'h1A5, 0, 32'h44332211, 3, 2);
        idle(12, 3, 2);
        // back-to-back, WL=4, held valid (R7)
        for (int i = 0; i < 10; i++) tick(1, i % 8, 17 * i, 0, 32'h01020304 * (i + 1), 4, 1);
        idle(10, 4, 1);
        // one idle cycle between bursts: postamble and preamble share a cycle (R5)
        tick(1, 3, 5, 0, 32'hA1B2C3D4, 2, 0);
        tick(0, 0, 0, 0, 0, 2, 0);
        tick(0, 0, 0, 0, 0, 2, 0);
        tick(1, 4, 6, 0, 32'h55AA33CC, 2, 0);
        idle(8, 2, 0);
        // latency drop while a burst is pending: stall (R6)
        tick(1, 1, 100, 0, 32'h0BADF00D, 6, 3);
        for (int i = 0; i < 9; i++) tick(1, 6, 200, 0, 32'hCAFE0000 + i, 2, 3);
        idle(10, 2, 3);
        // auto precharge write (R9)
        tick(1, 5, 33, 1, 32'h89ABCDEF, 2, 3);
        idle(12, 2, 3);
        tick(1, 5, 34, 0, 32'h76543210, 2, 15);
        idle(24, 2, 15);
        // WL=0 is refused, WL=1 has preamble in the command cycle, WL=7 (R6 R5)
        idle(2, 0, 0);
        tick(1, 0, 0, 0, 32'h11111111, 0, 0);
        tick(1, 0, 1, 0, 32'h22222222, 1, 0);
        idle(6, 1, 0);
        tick(1, 7, 300, 0, 32'h33333333, 7, 0);
        idle(14, 7, 0);
        // random mix
        begin
            int wl_r = 3;
            for (int i = 0; i < 600; i++) begin
                if (i % 9 == 0) wl_r = int'($urandom_range(0, 7));
                tick($urandom_range(0, 3) != 0, int'($urandom_range(0, 7)),
                     int'($urandom_range(0, 511)), $urandom_range(0, 3) == 0,
                     $urandom(), wl_r, int'($urandom_range(0, 15)));
            end
        end
        idle(30, 3, 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule